// File: doc/BRIEF.md
# Serial-Loaded Multiplexed Segment Display Controller

This block drives a passive segment display with three common lines and sixty-eight segment lines at one-third duty. A host controller loads a full display image over a three-wire link made of a select strobe, a shift clock and a data line. The block accepts an image only when the link first carries the block's own 8-bit address. It keeps the last image it accepted in a display register. A free-running frame sequencer then scans that register across the three commons, and each common's period is split into two halves of opposite polarity so the glass sees no net DC. Each drive pin is modelled as a 2-bit level code that stands for one of four bias levels: 0, one third, two thirds and full. The analog levels themselves are outside the block.

The first four segment pins can each be turned into a static output port by a mode bit in the image. A port pin then sits at level 0 or full, as its own level bit says. A blanking input, active low, forces every pin to level 0 and returns the port pins to segment duty. Serial loading goes on while the display is blanked. The link is sampled in the sequencer's clock domain, so the shift clock must stay well below that clock.

The link is a plain strobe/clock/data wire protocol and has no back-pressure. Every valid transfer is taken as soon as the strobe falls.

Top module: `segdrv_top`

## Requirements
- R1: After reset the display register holds all zeros, so every segment is off and no pin is in port mode. The sequencer starts at common 0, positive half, phase count 0.
- R2: The sequencer advances on every clock edge and the frame is 384 cycles long. Common k is active for frame cycles 128k to 128k+127. The first 64 of those cycles are the positive half and the last 64 are the negative half.
- R3: Common level codes are: active in the positive half 2'b11, active in the negative half 2'b00, inactive in the positive half 2'b01, inactive in the negative half 2'b10.
- R4: Segment s is lit during common c when image bit c*68+s is 1. Segment codes are: lit in the positive half 2'b00, lit in the negative half 2'b11, dark in the positive half 2'b10, dark in the negative half 2'b01.
- R5: While the strobe is low, each rising shift-clock edge shifts one address bit in, LSB first. The last 8 bits count. While the strobe is high, each rising edge shifts one image bit in, and the first bit becomes image bit 0.
- R6: A transfer whose address byte is not 8'h4B is discarded, and the displayed image is unchanged.
- R7: An image is taken only when exactly 212 image bits arrived while the strobe was high. A shorter or longer transfer leaves the image unchanged.
- R8: Image bit 204+p (p = 0..3) set puts segment pin p in port mode. The pin then drives 2'b11 if image bit 208+p is 1 and 2'b00 if it is 0, steady across the whole frame.
- R9: While the blanking input is low, every common and segment pin drives 2'b00, port pins included.
- R10: Transfers made while the display is blanked are stored, and they show as soon as blanking is released.
- R11: A new image reaches the pins on the third clock edge after the strobe goes low at the input. Until then, including while the transfer runs, the old image is shown.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock for the sequencer and the link sampling |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_ce | input | 1 | Link strobe: low for the address byte, high for the image, falling edge commits |
| ser_clk | input | 1 | Link shift clock, sampled on its rising edge |
| ser_din | input | 1 | Link data |
| inh_n | input | 1 | Display blanking, active low |
| com_lvl | output | 6 | Common level codes, 2 bits per common, common 0 in the low bits |
| seg_lvl | output | 136 | Segment level codes, 2 bits per segment, segment 0 in the low bits |

## Verification
Three functions can meet in one clock edge: the commit of a new image, the release of blanking and the sequencer's next step. The bench drops the strobe while the display is blanked and releases blanking exactly in the cycle before the commit edge. At the next sample point the pins must be unblanked and already showing the new image, with no stale cycle in between. The bench then checks every cycle of the next frame against its own model of the sequencer.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;

  typedef enum logic [1:0] {
    LVL_0 = 2'b00,
    LVL_1 = 2'b01,
    LVL_2 = 2'b10,
    LVL_3 = 2'b11
  } lvl_e;

  // common pin: full swing against the segment when active
  function automatic lvl_e com_code(input logic act, input logic neg);
    if (act) return neg ? LVL_0 : LVL_3;
    return neg ? LVL_2 : LVL_1;
  endfunction

  // segment pin: opposite rail to the active common when lit
  function automatic lvl_e seg_code(input logic lit, input logic neg);
    if (lit) return neg ? LVL_3 : LVL_0;
    return neg ? LVL_1 : LVL_2;
  endfunction

endpackage

// File: rtl/segdrv_serial_rx.sv
module segdrv_serial_rx #(
  parameter int          NBITS = 212,
  parameter int          AW    = 8,
  parameter logic [7:0]  ADDR  = 8'h4B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_ce,
  input  logic             ser_clk,
  input  logic             ser_din,
  output logic [NBITS-1:0] disp,
  output logic             ld
);
  localparam int CW = $clog2(NBITS + 2);

  logic [2:0]       ce_q, ck_q;
  logic [1:0]       di_q;
  logic [AW-1:0]    addr_sr;
  logic [NBITS-1:0] shreg;
  logic [CW-1:0]    bcnt;
  logic             hit;
  logic             ck_rise, ce_rise, ce_fall;

  assign ck_rise = ck_q[1] & ~ck_q[2];
  assign ce_rise = ce_q[1] & ~ce_q[2];
  assign ce_fall = ~ce_q[1] & ce_q[2];
  assign ld      = ce_fall & hit & (bcnt == CW'(NBITS));

  // two-stage synchronizers plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= '0;
      ck_q <= '0;
      di_q <= '0;
    end else begin
      ce_q <= {ce_q[1:0], ser_ce};
      ck_q <= {ck_q[1:0], ser_clk};
      di_q <= {di_q[0], ser_din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_sr <= '0;
      shreg   <= '0;
      bcnt    <= '0;
      hit     <= 1'b0;
    end else if (ce_rise) begin
      hit  <= (addr_sr == ADDR[AW-1:0]);
      bcnt <= '0;
    end else if (ce_fall) begin
      hit  <= 1'b0;
    end else if (ck_rise) begin
      if (!ce_q[1]) begin
        addr_sr <= {di_q[1], addr_sr[AW-1:1]};
      end else if (hit) begin
        if (bcnt < CW'(NBITS)) begin
          shreg <= {di_q[1], shreg[NBITS-1:1]};
          bcnt  <= bcnt + 1'b1;
        end else begin
          bcnt  <= CW'(NBITS + 1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  disp <= '0;
    else if (ld) disp <= shreg;
  end

endmodule

// File: rtl/segdrv_frame_timer.sv
module segdrv_frame_timer #(
  parameter int NCOM  = 3,
  parameter int PHASE = 128,
  parameter int CIW   = 2,
  parameter int PW    = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [CIW-1:0] ci,
  output logic [PW-1:0]  pc,
  output logic           pol
);
  localparam int HALF = PHASE / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ci <= '0;
      pc <= '0;
    end else if (pc == PW'(PHASE - 1)) begin
      pc <= '0;
      ci <= (ci == CIW'(NCOM - 1)) ? '0 : ci + 1'b1;
    end else begin
      pc <= pc + 1'b1;
    end
  end

  assign pol = (pc >= PW'(HALF));

endmodule

// File: rtl/segdrv_drive_mux.sv
module segdrv_drive_mux
  import segdrv_pkg::*;
#(
  parameter int NSEG  = 68,
  parameter int NCOM  = 3,
  parameter int NPORT = 4,
  parameter int CIW   = 2,
  parameter int NBITS = NSEG * NCOM + 2 * NPORT
) (
  input  logic [NBITS-1:0]    disp,
  input  logic [CIW-1:0]      ci,
  input  logic                pol,
  input  logic                inh_n,
  output logic [2*NCOM-1:0]   com_lvl,
  output logic [2*NSEG-1:0]   seg_lvl
);
  localparam int MODE_BASE  = NSEG * NCOM;
  localparam int LEVEL_BASE = MODE_BASE + NPORT;

  logic [NSEG-1:0] row;

  always_comb begin
    row = '0;
    for (int c = 0; c < NCOM; c++) begin
      if (ci == CIW'(c)) row = disp[c*NSEG +: NSEG];
    end
  end

  for (genvar c = 0; c < NCOM; c++) begin : g_com
    assign com_lvl[2*c +: 2] = inh_n ? com_code(ci == CIW'(c), pol) : LVL_0;
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    if (s < NPORT) begin : g_port
      logic [1:0] port_code;
      assign port_code = disp[LEVEL_BASE+s] ? LVL_3 : LVL_0;
      assign seg_lvl[2*s +: 2] = !inh_n            ? LVL_0 :
                                 disp[MODE_BASE+s] ? port_code :
                                 seg_code(row[s], pol);
    end else begin : g_plain
      assign seg_lvl[2*s +: 2] = inh_n ? seg_code(row[s], pol) : LVL_0;
    end
  end

endmodule

// File: rtl/segdrv_top.sv
module segdrv_top #(
  parameter int         NSEG      = 68,
  parameter int         NCOM      = 3,
  parameter int         NPORT     = 4,
  parameter int         FRAME_LEN = 384,
  parameter logic [7:0] ADDR      = 8'h4B
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_ce,
  input  logic                ser_clk,
  input  logic                ser_din,
  input  logic                inh_n,
  output logic [2*NCOM-1:0]   com_lvl,
  output logic [2*NSEG-1:0]   seg_lvl
);
  localparam int NBITS = NSEG * NCOM + 2 * NPORT;
  localparam int PHASE = FRAME_LEN / NCOM;
  localparam int PW    = $clog2(PHASE);
  localparam int CIW   = (NCOM > 1) ? $clog2(NCOM) : 1;

  logic [NBITS-1:0] disp;
  logic             ld;
  logic [CIW-1:0]   ci;
  logic [PW-1:0]    pc;
  logic             pol;

  segdrv_serial_rx #(.NBITS(NBITS), .AW(8), .ADDR(ADDR)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_ce(ser_ce), .ser_clk(ser_clk),
    .ser_din(ser_din), .disp(disp), .ld(ld)
  );

  segdrv_frame_timer #(.NCOM(NCOM), .PHASE(PHASE), .CIW(CIW), .PW(PW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ci(ci), .pc(pc), .pol(pol)
  );

  segdrv_drive_mux #(.NSEG(NSEG), .NCOM(NCOM), .NPORT(NPORT), .CIW(CIW), .NBITS(NBITS)) u_mux (
    .disp(disp), .ci(ci), .pol(pol), .inh_n(inh_n),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

endmodule

// File: rtl/segdrv_chk.sv
module segdrv_chk #(
  parameter int NSEG  = 68,
  parameter int NCOM  = 3,
  parameter int NPORT = 4,
  parameter int PHASE = 128,
  parameter int CIW   = 2,
  parameter int PW    = 7,
  parameter int NBITS = 212
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inh_n,
  input logic [2*NCOM-1:0]  com_lvl,
  input logic [2*NSEG-1:0]  seg_lvl,
  input logic [CIW-1:0]     ci,
  input logic [PW-1:0]      pc,
  input logic [NBITS-1:0]   disp,
  input logic               ld
);
  localparam int HALF       = PHASE / 2;
  localparam int MODE_BASE  = NSEG * NCOM;
  localparam int LEVEL_BASE = MODE_BASE + NPORT;

  logic            neg;
  logic [NCOM-1:0] act;

  assign neg = (pc >= PW'(HALF));

  always_comb begin
    for (int c = 0; c < NCOM; c++) act[c] = (com_lvl[2*c +: 2] == (neg ? 2'b00 : 2'b11));
  end

  assert_blank_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !inh_n |-> (com_lvl == '0 && seg_lvl == '0));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != PW'(PHASE - 1)) |=> (pc == $past(pc) + 1'b1 && ci == $past(ci)));

  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc == PW'(PHASE - 1)) |=>
      (pc == '0 && ci == (($past(ci) == CIW'(NCOM - 1)) ? '0 : $past(ci) + 1'b1)));

  assert_one_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inh_n |-> $countones(act) == 1);

  assert_image_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp) |-> $past(ld));

  for (genvar p = 0; p < NPORT; p++) begin : g_port_chk
    assert_port_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (inh_n && disp[MODE_BASE+p]) |->
        (seg_lvl[2*p +: 2] == (disp[LEVEL_BASE+p] ? 2'b11 : 2'b00)));
  end

endmodule

bind segdrv_top segdrv_chk #(
  .NSEG(NSEG), .NCOM(NCOM), .NPORT(NPORT), .PHASE(PHASE),
  .CIW(CIW), .PW(PW), .NBITS(NBITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .inh_n(inh_n), .com_lvl(com_lvl),
  .seg_lvl(seg_lvl), .ci(ci), .pc(pc), .disp(disp), .ld(ld)
);

// File: tb/segdrv_top_tb.sv
module segdrv_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG  = 68;
  localparam int NCOM  = 3;
  localparam int NBITS = 212;
  localparam int FRAME = 384;
  localparam logic [7:0] MY_ADDR = 8'h4B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_ce = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
  logic inh_n = 1'b1;
  logic [2*NCOM-1:0] com_lvl;
  logic [2*NSEG-1:0] seg_lvl;

  int nchk = 0;
  int nerr = 0;
  int mc;
  logic done = 1'b0;
  logic [NBITS-1:0] mdisp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segdrv_top u_dut (
    .clk(clk), .rst_n(rst_n), .ser_ce(ser_ce), .ser_clk(ser_clk),
    .ser_din(ser_din), .inh_n(inh_n), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // bench's own frame position, from R1/R2
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mc <= 0;
    else        mc <= (mc == FRAME - 1) ? 0 : mc + 1;
  end

  function automatic logic [1:0] want_com(int c);
    int  act = mc / 128;
    bit  ng  = (mc % 128) >= 64;
    if (!inh_n) return 2'b00;
    if (c == act) return ng ? 2'b00 : 2'b11;
    return ng ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [1:0] want_seg(int s);
    int  act = mc / 128;
    bit  ng  = (mc % 128) >= 64;
    if (!inh_n) return 2'b00;
    if (s < 4 && mdisp[204 + s]) return mdisp[208 + s] ? 2'b11 : 2'b00;
    if (mdisp[act*NSEG + s]) return ng ? 2'b11 : 2'b00;
    return ng ? 2'b01 : 2'b10;
  endfunction

  // compares all pins now; returns 1 on mismatch and reports the first one
  function automatic bit cmp_now(string tag);
    for (int c = 0; c < NCOM; c++)
      if (com_lvl[2*c +: 2] !== want_com(c)) begin
        $display("FAIL %s: com%0d at frame cycle %0d got %b expected %b",
                 tag, c, mc, com_lvl[2*c +: 2], want_com(c));
        return 1'b1;
      end
    for (int s = 0; s < NSEG; s++)
      if (seg_lvl[2*s +: 2] !== want_seg(s)) begin
        $display("FAIL %s: seg%0d at frame cycle %0d got %b expected %b",
                 tag, s, mc, seg_lvl[2*s +: 2], want_seg(s));
        return 1'b1;
      end
    return 1'b0;
  endfunction

  task automatic check_now(string tag);
    nchk++;
    if (cmp_now(tag)) nerr++;
  endtask

  task automatic sweep(string tag, int n);
    bit bad = 1'b0;
    nchk++;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!bad) bad = cmp_now(tag);
    end
    if (bad) nerr++;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(logic b);
    ser_din = b;
    tick(3);
    ser_clk = 1'b1;
    tick(3);
    ser_clk = 1'b0;
  endtask

  task automatic send_open(logic [7:0] a, logic [255:0] d, int n);
    @(negedge clk);
    ser_ce = 1'b0;
    for (int i = 0; i < 8; i++) put_bit(a[i]);
    tick(3);
    ser_ce = 1'b1;
    tick(3);
    for (int i = 0; i < n; i++) put_bit(d[i]);
    tick(3);
  endtask

  task automatic send_close();
    ser_ce = 1'b0;   // applied at a negedge
  endtask

  function automatic logic [255:0] pat(int k);
    logic [255:0] v = '0;
    for (int i = 0; i < 204; i++) v[i] = ((i * 7 + k) % 5) < 2;
    return v;
  endfunction

  task automatic t_reset();
    tick(1);
    check_now("R1 reset state");
    sweep("R2/R3/R4 blank frame", FRAME);
  endtask

  task automatic t_load();
    logic [255:0] d = pat(1);
    send_open(MY_ADDR, d, NBITS);
    sweep("R11 old image during transfer", 40);
    send_close();
    tick(2);
    check_now("R11 old image two edges after strobe low");
    mdisp = d[NBITS-1:0];
    tick(1);
    check_now("R11 new image on third edge");
    sweep("R4/R5 image A frame", FRAME);
  endtask

  task automatic t_common2();
    logic [255:0] d = '0;
    for (int s = 0; s < NSEG; s++) d[2*NSEG + s] = 1'b1;
    d[5] = 1'b1;
    send_open(MY_ADDR, d, NBITS);
    send_close();
    tick(6);
    mdisp = d[NBITS-1:0];
    sweep("R4/R5 common 2 lit", FRAME);
  endtask

  task automatic t_mismatch();
    logic [255:0] d = '1;
    send_open(8'hB4, d, NBITS);
    send_close();
    tick(6);
    sweep("R6 wrong address ignored", FRAME);
  endtask

  task automatic t_length();
    logic [255:0] d = pat(3);
    send_open(MY_ADDR, d, NBITS - 1);
    send_close();
    tick(6);
    sweep("R7 short transfer ignored", 200);
    send_open(MY_ADDR, d, NBITS + 1);
    send_close();
    tick(6);
    sweep("R7 long transfer ignored", 200);
  endtask

  task automatic t_ports();
    logic [255:0] d = '0;
    for (int i = 0; i < 204; i++) d[i] = 1'b1;
    d[204] = 1'b1; d[206] = 1'b1;        // pins 0 and 2 as ports
    d[208] = 1'b1; d[210] = 1'b0; d[209] = 1'b1; // pin 1 level bit set but not a port
    send_open(MY_ADDR, d, NBITS);
    send_close();
    tick(6);
    mdisp = d[NBITS-1:0];
    sweep("R8 port pins", FRAME);
  endtask

  task automatic t_inhibit();
    logic [255:0] d = pat(4);
    d[204] = 1'b1; d[208] = 1'b1;
    send_open(MY_ADDR, d, NBITS);
    send_close();
    tick(6);
    mdisp = d[NBITS-1:0];
    inh_n = 1'b0;
    sweep("R9 blanked incl. port pin", FRAME);
    d = pat(2);
    send_open(MY_ADDR, d, NBITS);
    send_close();
    tick(6);
    mdisp = d[NBITS-1:0];
    sweep("R9 still blanked after load", 50);
    inh_n = 1'b1;
    sweep("R10 blanked load shows", FRAME);
  endtask

  task automatic t_collide();
    logic [255:0] d = pat(0);
    d[207] = 1'b1; d[211] = 1'b1;
    inh_n = 1'b0;
    send_open(MY_ADDR, d, NBITS);
    send_close();
    tick(2);
    inh_n = 1'b1;                 // released in the cycle before the commit edge
    mdisp = d[NBITS-1:0];
    tick(1);
    check_now("R10/R11 release and commit together");
    sweep("R10 frame after collision", FRAME);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_common2();
    t_mismatch();
    t_length();
    t_ports();
    t_inhibit();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule